// File: doc/BRIEF.md
# Shared UART Baud Rate Generator

This block paces an asynchronous serial transmitter and receiver from one divisor, so both sides always run at the same rate. A down-counter loads the divisor, counts to zero, emits a one-cycle oversample tick and reloads. A small prescaler counts those ticks and raises a one-cycle bit tick once per bit time. The bit tick comes after 16 or 64 oversample ticks.

Two run-time mode bits set the counting. The wide bit picks between the low divisor byte alone and the full 16-bit high:low value. The speed bit, together with the wide bit, picks the oversampling ratio. When the divisor is written, the generator restarts from the new value. While the serial port is disabled, the generator holds its counters.

Top module: `uart_baud_gen`

## Requirements
- R1: With `wide_mode` low, the effective divisor D is `div_lo` alone, and `div_hi` has no effect on either tick.
- R2: With `wide_mode` high, the effective divisor D is the 16-bit value {`div_hi`, `div_lo`}.
- R3: While enabled and not reloaded, `os_tick` is high for exactly one cycle every D+1 clock cycles. When D is 0, it is high on every cycle.
- R4: The oversampling ratio N is 64 when `wide_mode` and `fast_mode` are both low. In the other three combinations, N is 16.
- R5: `bit_tick` is high only in a cycle where `os_tick` is high. It marks the oversample tick on which the prescaler wraps to zero, so it repeats every N oversample ticks.
- R6: A cycle with `div_load` high produces no tick. It reloads the counter with D and clears the prescaler. Counting from the first cycle after the load, the first `os_tick` comes D cycles later and the first `bit_tick` comes N*(D+1)-1 cycles later.
- R7: While `port_en` is low, both ticks stay low and the counter is held at D with the prescaler cleared. Counting from the first cycle with `port_en` high, the first `os_tick` comes D cycles later.
- R8: While `rst_n` is low, both ticks are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port enable; low holds the generator |
| wide_mode | input | 1 | 1 = 16-bit divisor, 0 = low byte only |
| fast_mode | input | 1 | Speed select; affects the ratio as in R4 |
| div_hi | input | 8 | High divisor byte |
| div_lo | input | 8 | Low divisor byte |
| div_load | input | 1 | Pulse on a divisor write; restarts the generator |
| os_tick | output | 1 | One-cycle oversample tick |
| bit_tick | output | 1 | One-cycle bit-rate tick |

## Verification
The bench builds the generator with its default parameters: 8-bit divisor bytes and ratios of 16 and 64. It drives all four mode combinations. This brings both prescaler lengths within reach, along with the 16-bit path through a divisor above 255 and the D=0 case, where a tick comes every cycle. A high byte that must be ignored in narrow mode is also covered. The 64x ratio is only paired with short divisors, so each bit time stays within a few hundred cycles.

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int BYTE_W       = 8,
  parameter int FINE_RATIO   = 16,
  parameter int COARSE_RATIO = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              wide_mode,
  input  logic              fast_mode,
  input  logic [BYTE_W-1:0] div_hi,
  input  logic [BYTE_W-1:0] div_lo,
  input  logic              div_load,
  output logic              os_tick,
  output logic              bit_tick
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam int PRE_W = $clog2(COARSE_RATIO);
  localparam logic [PRE_W-1:0] FINE_LAST   = PRE_W'(FINE_RATIO - 1);
  localparam logic [PRE_W-1:0] COARSE_LAST = PRE_W'(COARSE_RATIO - 1);

  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] reload;
  logic [PRE_W-1:0] pre_last;
  logic             pre_wrap;

  assign reload   = wide_mode ? {div_hi, div_lo} : {{BYTE_W{1'b0}}, div_lo};
  assign pre_last = (wide_mode | fast_mode) ? FINE_LAST : COARSE_LAST;
  assign pre_wrap = (pre >= pre_last);
  assign os_tick  = rst_n & port_en & ~div_load & (cnt == '0);
  assign bit_tick = os_tick & pre_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      pre <= '0;
    end else if (!port_en || div_load) begin
      cnt <= reload;
      pre <= '0;
    end else if (cnt == '0) begin
      cnt <= reload;
      pre <= pre_wrap ? '0 : pre + 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_en,
  input logic              wide_mode,
  input logic [BYTE_W-1:0] div_hi,
  input logic [BYTE_W-1:0] div_lo,
  input logic              div_load,
  input logic              os_tick,
  input logic              bit_tick
);
  logic d_nonzero;
  assign d_nonzero = (div_lo != '0) || (wide_mode && div_hi != '0);

  p_bit_on_os_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  p_quiet_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (!os_tick && !bit_tick));

  p_load_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |-> (!os_tick && !bit_tick));

  p_load_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_load && port_en && d_nonzero) |=> !os_tick);

  p_single_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && d_nonzero) |=> !os_tick);

  always_comb begin
    if (!rst_n) p_reset_quiet_r8: assert (!os_tick && !bit_tick);
  end
endmodule

bind uart_baud_gen uart_baud_gen_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .wide_mode(wide_mode),
  .div_hi(div_hi), .div_lo(div_lo), .div_load(div_load),
  .os_tick(os_tick), .bit_tick(bit_tick)
);

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // fields: {wide, fast, hi[7:0], lo[7:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h00, 8'h03},
    {1'b0, 1'b1, 8'h00, 8'h05},
    {1'b1, 1'b0, 8'h00, 8'h04},
    {1'b1, 1'b1, 8'h01, 8'h02},
    {1'b0, 1'b0, 8'hAB, 8'h02},
    {1'b0, 1'b1, 8'h00, 8'h00}
  };

  logic clk = 0, rst_n = 0, port_en = 0, wide_mode = 0, fast_mode = 0, div_load = 0;
  logic [7:0] div_hi = 0, div_lo = 0;
  logic os_tick, bit_tick;
  int checks = 0, fails = 0;
  int first_os, os_gap, first_bit;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .wide_mode(wide_mode),
    .fast_mode(fast_mode), .div_hi(div_hi), .div_lo(div_lo), .div_load(div_load),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_d(input logic w, input logic [7:0] h, input logic [7:0] l);
    return w ? int'({h, l}) : int'(l);
  endfunction

  function automatic int exp_n(input logic w, input logic f);
    return (w || f) ? 16 : 64;
  endfunction

  task automatic load(input logic w, input logic f, input logic [7:0] h, input logic [7:0] l);
    @(negedge clk);
    wide_mode = w; fast_mode = f; div_hi = h; div_lo = l; div_load = 1;
    @(negedge clk);
    div_load = 0;
  endtask

  // Caller is positioned at the negedge of cycle 0.
  task automatic measure();
    int prev;
    first_os = -1; os_gap = -1; first_bit = -1; prev = -1;
    for (int n = 0; n < 20000; n++) begin
      #1;
      if (os_tick) begin
        if (first_os < 0) first_os = n;
        else if (os_gap < 0) os_gap = n - prev;
        prev = n;
      end
      if (bit_tick && first_bit < 0) first_bit = n;
      if (first_bit >= 0 && os_gap >= 0) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    check("R8 os_tick in reset", os_tick, 0);
    check("R8 bit_tick in reset", bit_tick, 0);
    rst_n = 1;
    @(negedge clk);
    port_en = 1;

    for (int v = 0; v < NVEC; v++) begin
      logic w, f; logic [7:0] h, l; int d, nr;
      {w, f, h, l} = VEC[v];
      d = exp_d(w, h, l); nr = exp_n(w, f);
      load(w, f, h, l);
      measure();
      check($sformatf("R6 first os vec%0d", v), first_os, d);
      check($sformatf("R3 R1 R2 os period vec%0d", v), os_gap, d + 1);
      check($sformatf("R4 R5 first bit vec%0d", v), first_bit, nr * (d + 1) - 1);
    end

    // R7: disabled generator stays silent, then restarts from D
    load(1'b0, 1'b1, 8'h00, 8'h07);
    port_en = 0;
    seen = 0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk); #1;
      if (os_tick || bit_tick) seen++;
    end
    check("R7 ticks while disabled", seen, 0);
    @(negedge clk);
    port_en = 1;
    measure();
    check("R7 first os after enable", first_os, 7);
    check("R7 first bit after enable", first_bit, 16 * 8 - 1);

    // R6: mid-count rewrite restarts from the new divisor
    load(1'b0, 1'b1, 8'h00, 8'h09);
    seen = 0;
    for (int n = 0; n < 4; n++) begin
      #1; if (os_tick) seen++;
      @(negedge clk);
    end
    check("R6 no tick before rewrite", seen, 0);
    div_lo = 8'h06; div_load = 1;
    #1;
    check("R6 no tick on load cycle", int'(os_tick), 0);
    @(negedge clk);
    div_load = 0;
    measure();
    check("R6 first os after rewrite", first_os, 6);
    check("R6 first bit after rewrite", first_bit, 16 * 7 - 1);

    // R1: high byte change in narrow mode has no effect
    load(1'b0, 1'b1, 8'hFF, 8'h04);
    measure();
    check("R1 os period with high byte set", os_gap, 5);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule